// File: doc/BRIEF.md
# Phased Clock Divider

This block produces one output clock for a bank of a multi-phase clock generator. It runs on a fast tick clock whose period is one time unit (tU). It divides that tick stream down to an output period and places the rising edge a signed number of tU away from a shared zero-phase marker. The nominal period is N ticks. N is 32, 16 or 8, chosen by a frequency-select code. A pair of three-level selects picks a divide ratio from nine, and a second pair picks an offset from −4 tU to +4 tU.

All three-level inputs arrive already sensed, as 2-bit codes: `00` low, `01` mid, `10` high. An invalid code reads as mid. A zero-phase marker is a one-tick pulse on `ref_mark`. It starts the output after reset. It also realigns the output after the effective period or offset has changed. While the output runs in a stable configuration, markers change nothing, so several banks that share one marker stream stay aligned to it.

When parameter `FB_PHASE` is set, the instance becomes the feedback-output variant. Its offset comes from one three-level select, and the second phase select is ignored.

Top module: `phased_clock_divider`

## Requirements
- R1: The output period in ticks is N times the divide ratio. N is 32 for `fs_sel` = `00`, 16 for `01` and 8 for `10`.
- R2: The divide ratio is taken from index 3·hi + lo, where `div_sel_hi` and `div_sel_lo` rank low=0, mid=1, high=2. Indices 0 to 8 give ratios 1, 2, 3, 4, 5, 6, 8, 10, 12.
- R3: The offset in tU is the index 3·hi + lo of `ph_sel_hi` and `ph_sel_lo`, minus 4. After the edge that takes a marker, the output rises d edges later, where d is the offset modulo the period.
- R4: With a 0 tU offset, `clk_out` is high right after the clock edge that samples the marker.
- R5: In steady running, the output is high for floor(P/2) ticks and low for the rest of each P-tick period.
- R6: During and after reset, `clk_out` stays low until the first marker.
- R7: A change of the effective period or offset without a marker on the same edge drives `clk_out` low after that edge. The output then stays low until the next marker, where it resynchronises with the new setting.
- R8: A marker that arrives while the output runs and the setting is unchanged has no effect on the waveform.
- R9: Code `11` on any select is treated as mid. Rewriting a select between `01` and `11` while running has no effect.
- R10: With `FB_PHASE` = 1, `ph_sel_lo` alone selects the offset: low gives −4 tU, mid 0 tU and high +4 tU. `ph_sel_hi` is ignored.
- R11: After a resynchronisation the output stays low until its first rising edge, and that first high phase is full width, so a negative offset never yields a partial pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock, one period per tU |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_mark | input | 1 | One-tick zero-phase marker pulse |
| fs_sel | input | 2 | Frequency-select code (selects N) |
| div_sel_hi | input | 2 | Upper divide select code |
| div_sel_lo | input | 2 | Lower divide select code |
| ph_sel_hi | input | 2 | Upper phase select code (ignored in feedback variant) |
| ph_sel_lo | input | 2 | Lower phase select code |
| clk_out | output | 1 | Divided, phase-shifted output clock |

## Verification
The waveform check runs with each N and with ratios of 1, 2, 3, 4, 5 and 12. Positive, zero and negative offsets are all used, including −1 tU on the longest period. These settings separate a wrong period from a wrong offset, an off-by-one in the modulo wrap, and a partial first pulse. A normal instance and a feedback-variant instance share every stimulus, and settings are chosen where the two must differ, which shows whether the upper phase select is ignored.

Three further stimuli act on a running output:
- An extra marker off the phase grid shows whether stray markers realign the output.
- A rewrite of a code to its invalid alias shows whether decoding works on effective values.
- A mid-run divide change with no marker shows that the output parks low and then resynchronises at the next marker.

// File: rtl/cdv_pkg.sv
// Shared types and table functions for the phased clock divider.
// Assumes three-level pins arrive pre-sensed as 2-bit codes.
package cdv_pkg;

    typedef enum logic [1:0] {
        TRI_LOW  = 2'b00,
        TRI_MID  = 2'b01,
        TRI_HIGH = 2'b10
    } tri_e;

    // Clean a raw code: anything not low or high reads as mid.
    function automatic tri_e tri_clean(input logic [1:0] code);
        case (code)
            2'b00:   return TRI_LOW;
            2'b10:   return TRI_HIGH;
            default: return TRI_MID;
        endcase
    endfunction

    // Rank of a level: low=0, mid=1, high=2.
    function automatic logic [1:0] tri_rank(input tri_e lvl);
        case (lvl)
            TRI_LOW:  return 2'd0;
            TRI_HIGH: return 2'd2;
            default:  return 2'd1;
        endcase
    endfunction

    // Table index of a select pair: 3*hi + lo, range 0..8.
    function automatic logic [3:0] pair_index(input tri_e hi, input tri_e lo);
        return 4'(tri_rank(hi)) * 4'd3 + 4'(tri_rank(lo));
    endfunction

    // Divide ratio for a table index.
    function automatic logic [3:0] div_ratio(input logic [3:0] idx);
        case (idx)
            4'd0, 4'd1, 4'd2, 4'd3, 4'd4, 4'd5: return idx + 4'd1;
            4'd6:    return 4'd8;
            4'd7:    return 4'd10;
            default: return 4'd12;
        endcase
    endfunction

endpackage

// File: rtl/cdv_sel_decode.sv
// Select decoder: turns frequency, divide and phase codes into an output
// period in ticks and a rising-edge delay in ticks after the marker.
// Assumes FB_STEP and the centre offset (4) are smaller than N_HIGH, so a
// negative offset always wraps within one period.
module cdv_sel_decode #(
    parameter int N_LOW    = 32,
    parameter int N_MID    = 16,
    parameter int N_HIGH   = 8,
    parameter bit FB_PHASE = 1'b0,
    parameter int FB_STEP  = 4,
    parameter int PW       = 9
) (
    input  logic [1:0]    fs_code,
    input  logic [1:0]    div_hi,
    input  logic [1:0]    div_lo,
    input  logic [1:0]    ph_hi,
    input  logic [1:0]    ph_lo,
    output logic [PW-1:0] period_ticks,
    output logic [PW-1:0] delay_ticks
);
    import cdv_pkg::*;

    localparam logic [3:0] PH_CENTER = 4'd4;

    logic [PW-1:0] n_ticks;
    logic [3:0]    ratio;
    logic [3:0]    ph_idx;
    logic          off_neg;
    logic [PW-1:0] off_mag;

    // Base ticks per nominal period from the frequency-select code.
    always_comb begin
        case (tri_clean(fs_code))
            TRI_LOW:  n_ticks = PW'(N_LOW);
            TRI_HIGH: n_ticks = PW'(N_HIGH);
            default:  n_ticks = PW'(N_MID);
        endcase
    end

    // Divide ratio from the divide pair, then the period.
    always_comb begin
        ratio        = div_ratio(pair_index(tri_clean(div_hi), tri_clean(div_lo)));
        period_ticks = n_ticks * PW'(ratio);
    end

    // Signed offset as sign plus magnitude; the variant is picked by FB_PHASE.
    always_comb begin
        ph_idx = pair_index(tri_clean(ph_hi), tri_clean(ph_lo));
        if (FB_PHASE) begin
            case (tri_clean(ph_lo))
                TRI_LOW:  begin off_neg = 1'b1; off_mag = PW'(FB_STEP); end
                TRI_HIGH: begin off_neg = 1'b0; off_mag = PW'(FB_STEP); end
                default:  begin off_neg = 1'b0; off_mag = '0;           end
            endcase
        end else if (ph_idx < PH_CENTER) begin
            off_neg = 1'b1;
            off_mag = PW'(PH_CENTER - ph_idx);
        end else begin
            off_neg = 1'b0;
            off_mag = PW'(ph_idx - PH_CENTER);
        end
    end

    // Wrap a negative offset into a delay of (period - |k|) ticks.
    always_comb begin
        delay_ticks = off_neg ? (period_ticks - off_mag) : off_mag;
    end

endmodule

// File: rtl/cdv_cfg_watch.sv
// Configuration watcher: flags a one-cycle change whenever the effective
// period or delay differs from the value seen on the previous tick.
// Comparing decoded values makes code aliases (01 vs 11) invisible.
module cdv_cfg_watch #(
    parameter int PW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] period_ticks,
    input  logic [PW-1:0] delay_ticks,
    output logic          cfg_chg
);
    logic [2*PW-1:0] cfg_q;

    // Track the last effective setting; reset loads the present one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= {period_ticks, delay_ticks};
        end else begin
            cfg_q <= {period_ticks, delay_ticks};
        end
    end

    // A change is any difference from the previous tick's setting.
    always_comb begin
        cfg_chg = ({period_ticks, delay_ticks} != cfg_q);
    end

endmodule

// File: rtl/cdv_phase_gen.sv
// Phase generator: a modulo-period phase counter that is loaded at a
// marker so that it reaches zero 'delay' ticks later, plus a registered
// output that is high for the first half of each period. Output is parked
// low while idle and until the first full pulse after a load.
module cdv_phase_gen #(
    parameter int PW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ref_mark,
    input  logic          cfg_chg,
    input  logic [PW-1:0] period_ticks,
    input  logic [PW-1:0] delay_ticks,
    output logic          clk_out,
    output logic          run_active,
    output logic          sync_evt,
    output logic [PW-1:0] run_period
);
    logic          run_q;
    logic          armed_q;
    logic          out_q;
    logic [PW-1:0] ph_q;
    logic [PW-1:0] per_q;
    logic [PW-1:0] half_q;
    logic [PW-1:0] load_ph;
    logic [PW-1:0] adv_ph;
    logic          adv_wrap;

    // Resynchronise on a marker when idle or when the setting just changed.
    always_comb begin
        sync_evt = ref_mark && (!run_q || cfg_chg);
    end

    // Phase to load at a marker, and the free-running next phase.
    always_comb begin
        load_ph  = (delay_ticks == '0) ? '0 : (period_ticks - delay_ticks);
        adv_wrap = (ph_q == per_q - PW'(1));
        adv_ph   = adv_wrap ? '0 : (ph_q + PW'(1));
    end

    // Main state: load on sync, park on change, advance while running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q   <= 1'b0;
            armed_q <= 1'b0;
            out_q   <= 1'b0;
            ph_q    <= '0;
            per_q   <= '0;
            half_q  <= '0;
        end else if (sync_evt) begin
            run_q   <= 1'b1;
            per_q   <= period_ticks;
            half_q  <= period_ticks >> 1;
            ph_q    <= load_ph;
            armed_q <= (load_ph == '0);
            out_q   <= (load_ph == '0);
        end else if (cfg_chg) begin
            run_q   <= 1'b0;
            armed_q <= 1'b0;
            out_q   <= 1'b0;
        end else if (run_q) begin
            ph_q    <= adv_ph;
            armed_q <= armed_q || adv_wrap;
            out_q   <= (armed_q || adv_wrap) && (adv_ph < half_q);
        end
    end

    // Drive the status outputs seen by the top level.
    always_comb begin
        clk_out    = out_q;
        run_active = run_q;
        run_period = per_q;
    end

endmodule

// File: rtl/phased_clock_divider.sv
// Top level of one bank clock: decodes the selects, watches for setting
// changes and drives the phase generator. Runs entirely on the tU tick.
// Assumes ref_mark is a one-tick pulse synchronous to clk.
module phased_clock_divider #(
    parameter int N_LOW     = 32,
    parameter int N_MID     = 16,
    parameter int N_HIGH    = 8,
    parameter int MAX_RATIO = 12,
    parameter bit FB_PHASE  = 1'b0,
    parameter int FB_STEP   = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ref_mark,
    input  logic [1:0] fs_sel,
    input  logic [1:0] div_sel_hi,
    input  logic [1:0] div_sel_lo,
    input  logic [1:0] ph_sel_hi,
    input  logic [1:0] ph_sel_lo,
    output logic       clk_out
);
    localparam int MAX_NL = (N_LOW > N_MID) ? N_LOW : N_MID;
    localparam int MAX_N  = (MAX_NL > N_HIGH) ? MAX_NL : N_HIGH;
    localparam int PW     = $clog2(MAX_N * MAX_RATIO + 1);

    logic [PW-1:0] period_ticks;
    logic [PW-1:0] delay_ticks;
    logic [PW-1:0] run_period;
    logic          cfg_chg;
    logic          run_active;
    logic          sync_evt;

    cdv_sel_decode #(
        .N_LOW   (N_LOW),
        .N_MID   (N_MID),
        .N_HIGH  (N_HIGH),
        .FB_PHASE(FB_PHASE),
        .FB_STEP (FB_STEP),
        .PW      (PW)
    ) u_decode (
        .fs_code     (fs_sel),
        .div_hi      (div_sel_hi),
        .div_lo      (div_sel_lo),
        .ph_hi       (ph_sel_hi),
        .ph_lo       (ph_sel_lo),
        .period_ticks(period_ticks),
        .delay_ticks (delay_ticks)
    );

    cdv_cfg_watch #(
        .PW(PW)
    ) u_watch (
        .clk         (clk),
        .rst_n       (rst_n),
        .period_ticks(period_ticks),
        .delay_ticks (delay_ticks),
        .cfg_chg     (cfg_chg)
    );

    cdv_phase_gen #(
        .PW(PW)
    ) u_phase (
        .clk         (clk),
        .rst_n       (rst_n),
        .ref_mark    (ref_mark),
        .cfg_chg     (cfg_chg),
        .period_ticks(period_ticks),
        .delay_ticks (delay_ticks),
        .clk_out     (clk_out),
        .run_active  (run_active),
        .sync_evt    (sync_evt),
        .run_period  (run_period)
    );

endmodule

// File: rtl/cdv_checker.sv
// Property checker for the phased clock divider, bound into the top.
// Measures each clean high phase with a counter instead of a long $past.
module cdv_checker #(
    parameter int PW = 9
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ref_mark,
    input logic          clk_out,
    input logic          run_active,
    input logic          sync_evt,
    input logic          cfg_chg,
    input logic [PW-1:0] run_period,
    input logic [PW-1:0] delay_ticks
);
    logic          prev_out;
    logic          clean;
    logic [PW-1:0] hi_len;
    logic          rise;

    // Rising edge of the sampled output.
    always_comb begin
        rise = clk_out && !prev_out;
    end

    // Count the length of each high phase and whether it ran undisturbed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_out <= 1'b0;
            clean    <= 1'b0;
            hi_len   <= '0;
        end else begin
            prev_out <= clk_out;
            if (rise) begin
                hi_len <= PW'(1);
                clean  <= !(sync_evt || cfg_chg);
            end else begin
                if (clk_out) hi_len <= hi_len + PW'(1);
                clean <= clean && !sync_evt && !cfg_chg && run_active;
            end
        end
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !run_active |-> !clk_out);                                   // R6
    AST_ZERO_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_evt && (delay_ticks == '0)) |=> clk_out);              // R4
    AST_CHANGE_PARK: assert property (@(posedge clk) disable iff (!rst_n)
        (run_active && cfg_chg && !ref_mark) |=> (!run_active && !clk_out)); // R7
    AST_HIGH_TIME: assert property (@(posedge clk) disable iff (!rst_n)
        (prev_out && !clk_out && clean) |-> (hi_len == (run_period >> 1)));  // R5

endmodule

bind phased_clock_divider cdv_checker #(.PW(PW)) u_cdv_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ref_mark   (ref_mark),
    .clk_out    (clk_out),
    .run_active (run_active),
    .sync_evt   (sync_evt),
    .cfg_chg    (cfg_chg),
    .run_period (run_period),
    .delay_ticks(delay_ticks)
);

// File: tb/tb_phased_clock_divider.sv
// Directed bench: one task per scenario, a normal and a feedback-variant
// instance share all stimulus; waveforms are predicted from R1..R11.
module tb_phased_clock_divider;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref_mark = 1'b0;
    logic [1:0] fs_sel = 2'b10;
    logic [1:0] div_sel_hi = 2'b00;
    logic [1:0] div_sel_lo = 2'b00;
    logic [1:0] ph_sel_hi = 2'b01;
    logic [1:0] ph_sel_lo = 2'b01;
    logic       out_main;
    logic       out_fb;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    phased_clock_divider dut (
        .clk(clk), .rst_n(rst_n), .ref_mark(ref_mark), .fs_sel(fs_sel),
        .div_sel_hi(div_sel_hi), .div_sel_lo(div_sel_lo),
        .ph_sel_hi(ph_sel_hi), .ph_sel_lo(ph_sel_lo), .clk_out(out_main)
    );

    phased_clock_divider #(.FB_PHASE(1'b1)) dut_fb (
        .clk(clk), .rst_n(rst_n), .ref_mark(ref_mark), .fs_sel(fs_sel),
        .div_sel_hi(div_sel_hi), .div_sel_lo(div_sel_lo),
        .ph_sel_hi(ph_sel_hi), .ph_sel_lo(ph_sel_lo), .clk_out(out_fb)
    );

    function automatic bit exp_level(input int j, input int p, input int d);
        return (j >= d) && (((j - d) % p) < (p / 2));
    endfunction

    function automatic int wrap(input int k, input int p);
        return (k < 0) ? (p + k) : k;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic apply_reset();
        @(negedge clk);
        rst_n    = 1'b0;
        ref_mark = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic set_cfg(input logic [1:0] f, input logic [1:0] dh,
                           input logic [1:0] dl, input logic [1:0] phh,
                           input logic [1:0] phl);
        fs_sel     = f;
        div_sel_hi = dh;
        div_sel_lo = dl;
        ph_sel_hi  = phh;
        ph_sel_lo  = phl;
    endtask

    // Send a marker, then compare both outputs with the predicted waveform.
    task automatic run_wave(input int p, input int d, input int dfb,
                            input int mark_at, input int alias_at,
                            input string req);
        int ncyc;
        int bad_m = -1;
        int bad_f = -1;
        bit act_m = 1'b0;
        bit act_f = 1'b0;
        ncyc = ((d > dfb) ? d : dfb) + 2 * p + 2;
        @(negedge clk);
        ref_mark = 1'b1;
        for (int j = 0; j < ncyc; j++) begin
            @(negedge clk);
            ref_mark = 1'b0;
            if (bad_m < 0 && out_main !== exp_level(j, p, d)) begin
                bad_m = j; act_m = out_main;
            end
            if (bad_f < 0 && out_fb !== exp_level(j, p, dfb)) begin
                bad_f = j; act_f = out_fb;
            end
            if (j == mark_at) ref_mark = 1'b1;
            if (j == alias_at) ph_sel_hi = ph_sel_hi ^ 2'b10;
        end
        check(bad_m < 0, req, $sformatf("main level at tick %0d", bad_m),
              int'(act_m), (bad_m < 0) ? 0 : int'(exp_level(bad_m, p, d)));
        check(bad_f < 0, req, $sformatf("fb level at tick %0d", bad_f),
              int'(act_f), (bad_f < 0) ? 0 : int'(exp_level(bad_f, p, dfb)));
    endtask

    // R6: output low during reset and without a marker afterwards.
    task automatic t_reset();
        int high_seen = 0;
        set_cfg(2'b10, 2'b00, 2'b00, 2'b01, 2'b01);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check(out_main === 1'b0 && out_fb === 1'b0, "R6", "output in reset",
              int'(out_main | out_fb), 0);
        rst_n = 1'b1;
        for (int j = 0; j < 30; j++) begin
            @(negedge clk);
            if (out_main !== 1'b0 || out_fb !== 1'b0) high_seen++;
        end
        check(high_seen == 0, "R6", "high ticks before first marker", high_seen, 0);
    endtask

    // R1 R2 R4 R5: fastest setting, /1 with zero offset.
    task automatic t_fast_unity();
        set_cfg(2'b10, 2'b00, 2'b00, 2'b01, 2'b01);
        apply_reset();
        run_wave(8, 0, 0, -1, -1, "R1 R2 R4 R5 unity");
    endtask

    // R3: positive offset +4 on /2.
    task automatic t_pos_offset();
        set_cfg(2'b10, 2'b00, 2'b01, 2'b10, 2'b10);
        apply_reset();
        run_wave(16, 4, 4, -1, -1, "R3 R2 positive");
    endtask

    // R3 R11: negative offset -4 on /3, no partial first pulse.
    task automatic t_neg_offset();
        set_cfg(2'b10, 2'b00, 2'b10, 2'b00, 2'b00);
        apply_reset();
        run_wave(24, wrap(-4, 24), wrap(-4, 24), -1, -1, "R3 R11 negative");
    endtask

    // R1 R2 R3: N=32 with /5, +1 tU (fb +4).
    task automatic t_slow();
        set_cfg(2'b00, 2'b01, 2'b01, 2'b01, 2'b10);
        apply_reset();
        run_wave(160, 1, 4, -1, -1, "R1 R2 R3 slow");
    endtask

    // R1 R2 R11: N=16 with /12, -1 tU (fb -4).
    task automatic t_mid_big();
        set_cfg(2'b01, 2'b10, 2'b10, 2'b01, 2'b00);
        apply_reset();
        run_wave(192, wrap(-1, 192), wrap(-4, 192), -1, -1, "R1 R2 R11 long");
    endtask

    // R7: mid-run divide change parks low, next marker resynchronises.
    task automatic t_change_park();
        int high_seen = 0;
        set_cfg(2'b10, 2'b00, 2'b00, 2'b01, 2'b01);
        apply_reset();
        run_wave(8, 0, 0, -1, -1, "R7 before change");
        div_sel_lo = 2'b01;
        for (int j = 0; j < 40; j++) begin
            @(negedge clk);
            if (out_main !== 1'b0 || out_fb !== 1'b0) high_seen++;
        end
        check(high_seen == 0, "R7", "high ticks while parked", high_seen, 0);
        run_wave(16, 0, 0, -1, -1, "R7 after resync");
    endtask

    // R8: an off-grid marker while running is ignored.
    task automatic t_mark_ignored();
        set_cfg(2'b10, 2'b00, 2'b01, 2'b01, 2'b01);
        apply_reset();
        run_wave(16, 0, 0, 21, -1, "R8 stray marker");
    endtask

    // R9: code 11 reads as mid; aliasing 11->01 mid-run has no effect.
    task automatic t_alias();
        set_cfg(2'b11, 2'b11, 2'b00, 2'b11, 2'b11);
        apply_reset();
        run_wave(64, 0, 0, -1, 30, "R9 alias");
    endtask

    // R10: feedback variant ignores ph_sel_hi and maps high to +4.
    task automatic t_fb_variant();
        set_cfg(2'b10, 2'b00, 2'b00, 2'b00, 2'b10);
        apply_reset();
        run_wave(8, wrap(-2, 8), 4, -1, -1, "R10 R3 fb select");
    endtask

    initial begin
        t_reset();
        t_fast_unity();
        t_pos_offset();
        t_neg_offset();
        t_slow();
        t_mid_big();
        t_change_park();
        t_mark_ignored();
        t_alias();
        t_fb_variant();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog run did not complete actual 0 expected 1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule